// File: doc/BRIEF.md
# Sprite Priority Compositor with Palette

This block decides the final colour of each native-resolution pixel. Every pixel cycle, sixteen foreground sprite slots each offer a 3-bit colour index and a 3-bit palette select, and the background layer offers one more pair. The lowest-numbered slot that shows an opaque colour wins. If no slot is opaque, the background pair is used instead. Sprites always cover the background, and no option lets a sprite sit behind it.

The chosen pair is registered and then used as a 6-bit address into a 64-entry palette table of 12-bit RGB words. That lookup is a second registered stage. The CPU may rewrite the table at any time through a simple 16-bit write port. The block reports no collisions and no overflow. It only turns sampled pixel inputs into a colour word with a valid strobe, a fixed two clock edges later.

Top module: `pixel_compositor`

## Requirements
- R1: While reset is asserted and immediately after it, `outValid` is 0 and `outColor` is 0. Every palette entry reads as 0 until it is written.
- R2: Sprite slot k uses `sprIdx[3k+2:3k]` and `sprPal[3k+2:3k]`. Among the opaque slots, the one with the lowest k supplies both the colour index and the palette select.
- R3: Colour index 0 on a sprite slot is transparent. When all 16 slots are transparent, the background index and palette select are used. The background is opaque even when its index is 0.
- R4: Any opaque sprite replaces the background, whatever the background inputs hold.
- R5: The output colour is the palette entry at address `pal*8 + idx` of the winning pair.
- R6: A pixel sampled with `inValid` high at one rising edge appears on `outColor`, with `outValid` high for one cycle, after the next rising edge. `outValid` is low in every other cycle.
- R7: `outColor` keeps its last value in every cycle in which no new pixel result arrives.
- R8: A write with `cpuWe` high and `cpuAddr` from 0 to 63 stores `cpuWdata[11:0]` (bits 15:12 are dropped) into entry `cpuAddr`. Lookups at later edges return the new value.
- R9: A write with `cpuAddr` of 64 or above changes no palette entry.
- R10: A lookup and a write to the same entry at the same edge return the entry's old value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel pipeline clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| inValid | input | 1 | Sprite and background inputs hold a pixel this cycle |
| sprIdx | input | 48 | Colour index of each of the 16 sprite slots, 3 bits per slot, slot 0 in the low bits |
| sprPal | input | 48 | Palette select of each sprite slot, same packing as `sprIdx` |
| bgIdx | input | 3 | Background colour index |
| bgPal | input | 3 | Background palette select |
| cpuWe | input | 1 | Palette write strobe |
| cpuAddr | input | 16 | Palette write word address |
| cpuWdata | input | 16 | Palette write data, RGB in bits 11:0 |
| outValid | output | 1 | `outColor` carries a new pixel this cycle |
| outColor | output | 12 | Looked-up RGB colour, 4 bits per channel |

## Verification
Some properties are checked on every cycle. The assertions confirm that the valid strobe moves through both stages with no loss or extra pulse, and that the colour register holds between results. They also confirm that an opaque sprite always leaves a non-zero index in the stage register, that a fully transparent set leaves exactly the background pair, and that an in-range write lands in the entry it addresses. Other behaviour is shown only by the bench scenarios, where the reference model follows each pixel end to end. These are the ordering among several opaque slots, the exact colour looked up, dropped out-of-range writes with no aliasing, and the old value returned when a write and a lookup meet at the same edge.

// File: rtl/comp_pkg.sv
package comp_pkg;

  localparam int IDX_W = 3;
  localparam int PAL_W = 3;
  localparam int SEL_W = IDX_W + PAL_W;
  localparam int TABLE_ENTRIES = 1 << SEL_W;

  typedef struct packed {
    logic [PAL_W-1:0] pal;
    logic [IDX_W-1:0] idx;
  } pixSel_t;

  typedef struct packed {
    logic capEn;
    logic lookEn;
    logic tabWr;
  } ctrlStrobes_t;

endpackage

// File: rtl/sprite_priority_pick.sv
module sprite_priority_pick
  import comp_pkg::*;
#(
  parameter int NUM_SPR = 16
) (
  input  logic [NUM_SPR*IDX_W-1:0] sprIdx,
  input  logic [NUM_SPR*PAL_W-1:0] sprPal,
  input  pixSel_t                  bgSel,
  output pixSel_t                  winSel,
  output logic                     anyOpaque
);

  logic [NUM_SPR-1:0] opaque;
  logic [NUM_SPR-1:0] firstHot;
  pixSel_t            sprWin;

  genvar k;
  generate
    for (k = 0; k < NUM_SPR; k++) begin : gOpaque
      assign opaque[k] = |sprIdx[k*IDX_W +: IDX_W];
    end
  endgenerate

  // isolate the lowest set bit: lowest-numbered opaque slot
  assign firstHot  = opaque & (~opaque + NUM_SPR'(1));
  assign anyOpaque = |opaque;

  always_comb begin
    sprWin = '0;
    for (int i = 0; i < NUM_SPR; i++) begin
      if (firstHot[i]) begin
        sprWin.idx = sprWin.idx | sprIdx[i*IDX_W +: IDX_W];
        sprWin.pal = sprWin.pal | sprPal[i*PAL_W +: PAL_W];
      end
    end
  end

  assign winSel = anyOpaque ? sprWin : bgSel;

endmodule

// File: rtl/comp_ctrl.sv
module comp_ctrl
  import comp_pkg::*;
#(
  parameter int BUS_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inValid,
  input  logic             cpuWe,
  input  logic [BUS_W-1:0] cpuAddr,
  output ctrlStrobes_t     strobes,
  output logic             outValid
);

  localparam logic [BUS_W-1:0] TAB_LIMIT = BUS_W'(TABLE_ENTRIES);

  logic stageValid;
  logic lookValid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stageValid <= 1'b0;
      lookValid  <= 1'b0;
    end else begin
      stageValid <= inValid;
      lookValid  <= stageValid;
    end
  end

  always_comb begin
    strobes.capEn  = inValid;
    strobes.lookEn = stageValid;
    strobes.tabWr  = cpuWe && (cpuAddr < TAB_LIMIT);
  end

  assign outValid = lookValid;

  // R6: a sampled pixel moves through both stages, one edge each
  assert_stage_follows_R6: assert property (@(posedge clk) disable iff (!rst_n)
    inValid |=> stageValid);
  assert_output_follows_R6: assert property (@(posedge clk) disable iff (!rst_n)
    stageValid |=> outValid);
  assert_no_spurious_valid_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !stageValid |=> !outValid);

endmodule

// File: rtl/comp_datapath.sv
module comp_datapath
  import comp_pkg::*;
#(
  parameter int NUM_SPR = 16,
  parameter int RGB_W   = 12
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  ctrlStrobes_t             strobes,
  input  logic [NUM_SPR*IDX_W-1:0] sprIdx,
  input  logic [NUM_SPR*PAL_W-1:0] sprPal,
  input  logic [IDX_W-1:0]         bgIdx,
  input  logic [PAL_W-1:0]         bgPal,
  input  logic [SEL_W-1:0]         wrAddr,
  input  logic [RGB_W-1:0]         wrData,
  output logic [RGB_W-1:0]         outColor
);

  pixSel_t bgSel;
  pixSel_t winSel;
  pixSel_t stageSel;
  logic    anyOpaque;

  logic [RGB_W-1:0] palTab [TABLE_ENTRIES];

  assign bgSel.idx = bgIdx;
  assign bgSel.pal = bgPal;

  sprite_priority_pick #(
    .NUM_SPR(NUM_SPR)
  ) uPick (
    .sprIdx   (sprIdx),
    .sprPal   (sprPal),
    .bgSel    (bgSel),
    .winSel   (winSel),
    .anyOpaque(anyOpaque)
  );

  // stage 1: composite result
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stageSel <= '0;
    end else if (strobes.capEn) begin
      stageSel <= winSel;
    end
  end

  // palette storage
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int e = 0; e < TABLE_ENTRIES; e++) palTab[e] <= '0;
    end else if (strobes.tabWr) begin
      palTab[wrAddr] <= wrData;
    end
  end

  // stage 2: colour lookup (reads the pre-write contents)
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      outColor <= '0;
    end else if (strobes.lookEn) begin
      outColor <= palTab[{stageSel.pal, stageSel.idx}];
    end
  end

  assert_hold_color_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !strobes.lookEn |=> $stable(outColor));
  assert_sprite_wins_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (strobes.capEn && anyOpaque) |=> (stageSel.idx != '0));
  assert_bg_fallback_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (strobes.capEn && !anyOpaque) |=> (stageSel == $past(bgSel)));
  assert_write_lands_R8: assert property (@(posedge clk) disable iff (!rst_n)
    strobes.tabWr |=> (palTab[$past(wrAddr)] == $past(wrData)));

endmodule

// File: rtl/pixel_compositor.sv
module pixel_compositor
  import comp_pkg::*;
#(
  parameter int NUM_SPR = 16,
  parameter int RGB_W   = 12,
  parameter int BUS_W   = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     inValid,
  input  logic [NUM_SPR*IDX_W-1:0] sprIdx,
  input  logic [NUM_SPR*PAL_W-1:0] sprPal,
  input  logic [IDX_W-1:0]         bgIdx,
  input  logic [PAL_W-1:0]         bgPal,
  input  logic                     cpuWe,
  input  logic [BUS_W-1:0]         cpuAddr,
  input  logic [BUS_W-1:0]         cpuWdata,
  output logic                     outValid,
  output logic [RGB_W-1:0]         outColor
);

  ctrlStrobes_t strobes;
  logic         unusedWdataHi;

  assign unusedWdataHi = ^cpuWdata[BUS_W-1:RGB_W];

  comp_ctrl #(
    .BUS_W(BUS_W)
  ) uCtrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .inValid (inValid),
    .cpuWe   (cpuWe),
    .cpuAddr (cpuAddr),
    .strobes (strobes),
    .outValid(outValid)
  );

  comp_datapath #(
    .NUM_SPR(NUM_SPR),
    .RGB_W  (RGB_W)
  ) uDp (
    .clk     (clk),
    .rst_n   (rst_n),
    .strobes (strobes),
    .sprIdx  (sprIdx),
    .sprPal  (sprPal),
    .bgIdx   (bgIdx),
    .bgPal   (bgPal),
    .wrAddr  (cpuAddr[SEL_W-1:0]),
    .wrData  (cpuWdata[RGB_W-1:0]),
    .outColor(outColor)
  );

endmodule

// File: tb/tb_pixel_compositor.sv
`timescale 1ns/1ps
module tb_pixel_compositor;

  localparam int NSPR = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          inValid = 1'b0;
  logic [NSPR*3-1:0] sprIdx = '0;
  logic [NSPR*3-1:0] sprPal = '0;
  logic [2:0]    bgIdx = '0;
  logic [2:0]    bgPal = '0;
  logic          cpuWe = 1'b0;
  logic [15:0]   cpuAddr = '0;
  logic [15:0]   cpuWdata = '0;
  logic          outValid;
  logic [11:0]   outColor;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  string curReq = "R1";
  logic [31:0] rng = 32'h1234_5679;

  always #10 clk = ~clk;

  pixel_compositor dut (
    .clk(clk), .rst_n(rst_n), .inValid(inValid),
    .sprIdx(sprIdx), .sprPal(sprPal), .bgIdx(bgIdx), .bgPal(bgPal),
    .cpuWe(cpuWe), .cpuAddr(cpuAddr), .cpuWdata(cpuWdata),
    .outValid(outValid), .outColor(outColor)
  );

  // behavioural reference model
  int mTab [64];
  int mAddr1;
  bit mV1;
  bit mOutV;
  int mOutC;

  function automatic int pickAddr();
    for (int k = 0; k < NSPR; k++) begin
      if (sprIdx[k*3 +: 3] != 3'd0) return int'(sprPal[k*3 +: 3]) * 8 + int'(sprIdx[k*3 +: 3]);
    end
    return int'(bgPal) * 8 + int'(bgIdx);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 64; i++) mTab[i] = 0;
      mAddr1 = 0; mV1 = 0; mOutV = 0; mOutC = 0;
    end else begin
      if (mV1) mOutC = mTab[mAddr1];
      mOutV = mV1;
      if (cpuWe && cpuAddr < 16'd64) mTab[cpuAddr] = int'(cpuWdata) & 32'hFFF;
      mV1 = inValid;
      if (inValid) mAddr1 = pickAddr();
    end
  end

  function automatic logic [31:0] nextRand();
    rng = rng ^ (rng << 13);
    rng = rng ^ (rng >> 17);
    rng = rng ^ (rng << 5);
    return rng;
  endfunction

  // wait one cycle, then compare at the falling edge
  task automatic step();
    @(negedge clk);
    checks++;
    if (outValid !== mOutV || outColor !== mOutC[11:0]) begin
      errors++;
      $display("FAIL %s: outValid=%0b outColor=%03h, expected outValid=%0b outColor=%03h",
               curReq, outValid, outColor, mOutV, mOutC[11:0]);
    end
  endtask

  task automatic clearPix();
    inValid = 0; sprIdx = '0; sprPal = '0; bgIdx = 0; bgPal = 0;
  endtask

  task automatic setSpr(int k, logic [2:0] idx, logic [2:0] pal);
    sprIdx[k*3 +: 3] = idx;
    sprPal[k*3 +: 3] = pal;
  endtask

  task automatic writeEntry(logic [15:0] a, logic [15:0] d);
    cpuWe = 1; cpuAddr = a; cpuWdata = d;
    step();
    cpuWe = 0;
  endtask

  task automatic bgSweep();
    for (int e = 0; e < 64; e++) begin
      clearPix();
      inValid = 1; bgPal = 3'(e / 8); bgIdx = 3'(e % 8);
      step();
    end
    clearPix();
    step(); step(); step();
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      checks++; errors++;
      $display("FAIL watchdog: cycles=%0d, expected fewer than 100000", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    curReq = "R1";
    repeat (3) begin
      @(negedge clk);
      checks++;
      if (outValid !== 1'b0 || outColor !== 12'h000) begin
        errors++;
        $display("FAIL R1: outValid=%0b outColor=%03h, expected 0 and 000", outValid, outColor);
      end
    end
    rst_n = 1;
    step();
    bgSweep();                      // R1: all entries zero

    // R8: program table, upper data bits must be dropped
    curReq = "R8";
    for (int e = 0; e < 64; e++) writeEntry(16'(e), 16'hF000 | 16'((e * 397 + 91) & 12'hFFF));
    curReq = "R5";
    bgSweep();                      // R5: background lookup of every entry

    // R2/R4: single opaque sprite in each slot over a busy background
    curReq = "R4";
    for (int k = 0; k < NSPR; k++) begin
      clearPix(); inValid = 1; bgIdx = 3'd5; bgPal = 3'd6;
      setSpr(k, 3'(1 + k % 7), 3'(k % 8));
      step();
    end
    // R2: two opaque slots, lower one must win
    curReq = "R2";
    for (int k = 0; k < NSPR - 1; k++) begin
      clearPix(); inValid = 1;
      setSpr(k + 1, 3'd7, 3'd7);
      setSpr(k, 3'(1 + (k + 3) % 7), 3'((k + 2) % 8));
      step();
    end
    // R3: all transparent, background with index 0 still shows
    curReq = "R3";
    for (int p = 0; p < 8; p++) begin
      clearPix(); inValid = 1; bgIdx = 3'd0; bgPal = 3'(p);
      for (int k = 0; k < NSPR; k++) sprPal[k*3 +: 3] = 3'(7 - p);
      step();
    end
    // R6/R7: mixed valid gaps with random sparse sprites
    curReq = "R6";
    for (int n = 0; n < 600; n++) begin
      logic [31:0] r;
      clearPix();
      r = nextRand();
      inValid = (r[1:0] != 2'b00);
      bgIdx = r[4:2]; bgPal = r[7:5];
      for (int k = 0; k < NSPR; k++) begin
        r = nextRand();
        if (r[2:0] == 3'd0) setSpr(k, r[5:3] == 3'd0 ? 3'd1 : r[5:3], r[8:6]);
        else sprPal[k*3 +: 3] = r[11:9];
      end
      if (n == 300) curReq = "R7";
      step();
    end
    clearPix();
    curReq = "R7";
    repeat (5) step();

    // R9: out-of-range writes are dropped, no aliasing
    curReq = "R9";
    writeEntry(16'd64,   16'h0ABC);
    writeEntry(16'd127,  16'h0DEF);
    writeEntry(16'h8013, 16'h0123);
    writeEntry(16'hFFFF, 16'h0FFF);
    bgSweep();

    // R10: write and lookup of the same entry at the same edge
    curReq = "R10";
    for (int t = 0; t < 4; t++) begin
      clearPix(); inValid = 1; bgPal = 3'd2; bgIdx = 3'(3 + t);
      step();                               // pixel sampled
      clearPix();
      cpuWe = 1; cpuAddr = 16'(19 + t); cpuWdata = 16'(12'h5A0 + t);
      step();                               // lookup and write share this edge
      cpuWe = 0;
      inValid = 1; bgPal = 3'd2; bgIdx = 3'(3 + t);
      step();
      clearPix();
      step(); step();
    end

    // R8: mid-stream rewrite while pixels flow
    curReq = "R8";
    for (int n = 0; n < 64; n++) begin
      clearPix(); inValid = 1; bgPal = 3'(n / 8); bgIdx = 3'(n % 8);
      cpuWe = 1; cpuAddr = 16'((n + 1) % 64); cpuWdata = 16'(12'hC00 | n);
      step();
    end
    cpuWe = 0; clearPix();
    bgSweep();

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule